// File: doc/BRIEF.md
# Multiplexed LED Grid Scanner with Dimming

The scanner drives a common-cathode LED panel. It pulls one grid line low at a time and presents that digit's segment pattern, which it takes from a 14-byte display memory supplied as a flat input vector. One scan frame visits every grid slot and then a key-scan slot in which all grids are dark. A one-cycle latch pulse marks the end of the display part of the frame, so that a key matrix wired to the segment lines can be sampled at that point.

There are two panel layouts. In the first, six grids drive twelve segments. In the second, seven grids drive eleven segments. One physical output serves as segment 12 in the first layout and as grid 7 in the second. A three-bit brightness code sets how long segments stay lit within each 16-tick grid slot, following a non-linear table. A display enable blanks all outputs but leaves the scan timing running. Mode and brightness are loaded through write strobes, in the same way as commands.

Top module: `led_scan_top`

## Requirements
- R1: After reset the 7-grid mode is active, the brightness code is 0 and the display is off: `grid_o` is all ones, `shared_o` is 1, `seg_o` is zero, and the scan starts at grid 1, tick 0.
- R2: A mode write with code 2'b10 selects 6 grids and 12 segments. Code 2'b11 selects 7 grids and 11 segments. Codes 2'b00 and 2'b01 have no effect.
- R3: In 6-grid mode `shared_o` is segment 12 (active high, lit like the other segments). In 7-grid mode it is grid 7 (active low).
- R4: Digit n (0-based slot n) takes segments 1..8 from byte 2n, with bit 0 driving segment 1, and segments 9..12 from bits 3:0 of byte 2n+1. Byte k sits at `ram_i[8k+7:8k]`. Bits 7:4 of odd bytes are never shown, and neither is segment 12 in 7-grid mode.
- R5: Each grid slot lasts 16 `tick_i` pulses. Grids are visited in ascending order, only the current grid is low (for the whole slot, while enabled), and at most one grid is low at any time.
- R6: Within a grid slot, segments are lit while the tick index is below the on-time of the brightness code. For codes 0..7 the on-times are 1, 2, 4, 10, 11, 12, 13 and 14 ticks. Outside that window the segments read zero.
- R7: While the display is off, all grids are high and all segments are low, yet the slot timing, `key_win_o` and `key_latch_o` keep running.
- R8: A mode write that changes the mode turns the display off and restarts the scan at grid 1, tick 0. A mode write that names the mode already selected changes nothing.
- R9: `key_latch_o` pulses for one clock as the last grid slot ends. It coincides with the first cycle of a 16-tick key slot, during which `key_win_o` is high, all grids are inactive and the segments are zero.
- R10: A control write loads the brightness code and the display enable. If it arrives in the same cycle as a mode-changing write, the control write's enable wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Scan tick enable |
| ram_i | input | 112 | Display memory, byte k at bits 8k+7:8k |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_i | input | 2 | Mode code |
| ctrl_wr_i | input | 1 | Control write strobe |
| dim_i | input | 3 | Brightness code |
| disp_en_i | input | 1 | Display enable value for a control write |
| seg_o | output | 11 | Segments 1..11, active high |
| grid_o | output | 6 | Grids 1..6, active low |
| shared_o | output | 1 | Segment 12 (6-grid mode) or grid 7 (7-grid mode) |
| key_win_o | output | 1 | High during the key-scan slot |
| key_latch_o | output | 1 | One-cycle pulse at the end of the grid slots |

## Verification
The checks assume that reset is applied with the clock running, so that every past-value reference sees a reset state. They also assume that the write strobes are single-cycle and that `ram_i` may change at any time, because segments follow it combinationally. The stimulus changes inputs only on falling edges. It spaces `tick_i` either every cycle or every third cycle. It issues mode and control writes in the middle of slots, in the middle of the key slot, and in the same cycle as each other, and it rewrites the memory with patterns that set the unused bits.

// File: rtl/led_scan_pkg.sv
package led_scan_pkg;
  localparam int unsigned TICK_W = 4;
  localparam int unsigned DIM_W  = 3;
  localparam int unsigned ON_W   = TICK_W + 1;

  // on-time in ticks per 16-tick slot
  function automatic logic [ON_W-1:0] on_ticks(input logic [DIM_W-1:0] code);
    logic [ON_W-1:0] r;
    case (code)
      3'd0: r = 5'd1;
      3'd1: r = 5'd2;
      3'd2: r = 5'd4;
      3'd3: r = 5'd10;
      3'd4: r = 5'd11;
      3'd5: r = 5'd12;
      3'd6: r = 5'd13;
      default: r = 5'd14;
    endcase
    return r;
  endfunction
endpackage

// File: rtl/led_scan_ctrl.sv
module led_scan_ctrl
  import led_scan_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_wr_i,
  input  logic [1:0]       mode_i,
  input  logic             ctrl_wr_i,
  input  logic [DIM_W-1:0] dim_i,
  input  logic             disp_en_i,
  output logic             mode7_o,
  output logic [DIM_W-1:0] dim_o,
  output logic             en_o,
  output logic             restart_o
);
  logic             mode7_q, en_q;
  logic [DIM_W-1:0] dim_q;

  // only codes with the upper bit set are modes; same mode is a no-op
  assign restart_o = mode_wr_i && mode_i[1] && (mode_i[0] != mode7_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode7_q <= 1'b1;
      en_q    <= 1'b0;
      dim_q   <= '0;
    end else begin
      if (restart_o) begin
        mode7_q <= mode_i[0];
        en_q    <= 1'b0;
      end
      if (ctrl_wr_i) begin
        dim_q <= dim_i;
        en_q  <= disp_en_i;
      end
    end
  end

  assign mode7_o = mode7_q;
  assign dim_o   = dim_q;
  assign en_o    = en_q;
endmodule

// File: rtl/led_scan_timer.sv
module led_scan_timer
  import led_scan_pkg::*;
#(
  parameter int unsigned MAX_GRIDS = 7,
  localparam int unsigned SLOT_W   = $clog2(MAX_GRIDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              restart_i,
  input  logic              mode7_i,
  output logic [SLOT_W-1:0] slot_o,
  output logic [TICK_W-1:0] tick_o,
  output logic              key_win_o,
  output logic              key_latch_o
);
  localparam logic [TICK_W-1:0] TICK_LAST = '1;

  logic [SLOT_W-1:0] slot_q, n_grids;
  logic [TICK_W-1:0] tick_q;
  logic              latch_q, slot_end;

  assign n_grids  = mode7_i ? SLOT_W'(MAX_GRIDS) : SLOT_W'(MAX_GRIDS - 1);
  assign slot_end = tick_i && (tick_q == TICK_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q  <= '0;
      tick_q  <= '0;
      latch_q <= 1'b0;
    end else begin
      latch_q <= slot_end && !restart_i && (slot_q == n_grids - SLOT_W'(1));
      if (restart_i) begin
        slot_q <= '0;
        tick_q <= '0;
      end else if (tick_i) begin
        tick_q <= tick_q + TICK_W'(1);
        if (slot_end) slot_q <= (slot_q == n_grids) ? '0 : slot_q + SLOT_W'(1);
      end
    end
  end

  assign slot_o      = slot_q;
  assign tick_o      = tick_q;
  assign key_win_o   = (slot_q == n_grids);
  assign key_latch_o = latch_q;
endmodule

// File: rtl/led_scan_drive.sv
module led_scan_drive
  import led_scan_pkg::*;
#(
  parameter int unsigned MAX_GRIDS = 7,
  localparam int unsigned SLOT_W   = $clog2(MAX_GRIDS + 1),
  localparam int unsigned RAM_W    = 16 * MAX_GRIDS
) (
  input  logic [RAM_W-1:0]     ram_i,
  input  logic [SLOT_W-1:0]    slot_i,
  input  logic [TICK_W-1:0]    tick_i,
  input  logic                 mode7_i,
  input  logic                 en_i,
  input  logic [DIM_W-1:0]     dim_i,
  output logic [10:0]          seg_o,
  output logic [MAX_GRIDS-2:0] grid_o,
  output logic                 shared_o
);
  logic [SLOT_W-1:0] n_grids;
  logic [7:0]        lo_byte;
  logic [3:0]        hi_nib;
  logic              lit;

  assign n_grids = mode7_i ? SLOT_W'(MAX_GRIDS) : SLOT_W'(MAX_GRIDS - 1);
  assign lit     = en_i && (slot_i < n_grids) && ({1'b0, tick_i} < on_ticks(dim_i));

  always_comb begin
    lo_byte = '0;
    hi_nib  = '0;
    for (int d = 0; d < MAX_GRIDS; d++) begin
      if (slot_i == SLOT_W'(d)) begin
        lo_byte = ram_i[16*d +: 8];
        hi_nib  = ram_i[16*d+8 +: 4];
      end
    end
  end

  assign seg_o = lit ? {hi_nib[2:0], lo_byte} : '0;

  for (genvar g = 0; g < MAX_GRIDS - 1; g++) begin : g_grid
    assign grid_o[g] = !(en_i && (slot_i == SLOT_W'(g)));
  end

  assign shared_o = mode7_i ? !(en_i && (slot_i == SLOT_W'(MAX_GRIDS - 1)))
                            : (lit && hi_nib[3]);
endmodule

// File: rtl/led_scan_top.sv
module led_scan_top
  import led_scan_pkg::*;
#(
  parameter int unsigned MAX_GRIDS = 7,
  localparam int unsigned SLOT_W   = $clog2(MAX_GRIDS + 1),
  localparam int unsigned RAM_W    = 16 * MAX_GRIDS
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic [RAM_W-1:0]     ram_i,
  input  logic                 mode_wr_i,
  input  logic [1:0]           mode_i,
  input  logic                 ctrl_wr_i,
  input  logic [DIM_W-1:0]     dim_i,
  input  logic                 disp_en_i,
  output logic [10:0]          seg_o,
  output logic [MAX_GRIDS-2:0] grid_o,
  output logic                 shared_o,
  output logic                 key_win_o,
  output logic                 key_latch_o
);
  logic              mode7, en, restart;
  logic [DIM_W-1:0]  dim;
  logic [SLOT_W-1:0] slot;
  logic [TICK_W-1:0] tick;

  led_scan_ctrl u_ctrl (
    .clk_i, .rst_ni, .mode_wr_i, .mode_i, .ctrl_wr_i, .dim_i, .disp_en_i,
    .mode7_o(mode7), .dim_o(dim), .en_o(en), .restart_o(restart)
  );

  led_scan_timer #(.MAX_GRIDS(MAX_GRIDS)) u_timer (
    .clk_i, .rst_ni, .tick_i, .restart_i(restart), .mode7_i(mode7),
    .slot_o(slot), .tick_o(tick), .key_win_o, .key_latch_o
  );

  led_scan_drive #(.MAX_GRIDS(MAX_GRIDS)) u_drive (
    .ram_i, .slot_i(slot), .tick_i(tick), .mode7_i(mode7), .en_i(en),
    .dim_i(dim), .seg_o, .grid_o, .shared_o
  );
endmodule

// File: rtl/led_scan_chk.sv
module led_scan_chk #(
  parameter int unsigned MAX_GRIDS = 7
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 ctrl_wr_i,
  input logic [10:0]          seg_o,
  input logic [MAX_GRIDS-2:0] grid_o,
  input logic                 shared_o,
  input logic                 key_win_o,
  input logic                 key_latch_o,
  input logic                 mode7,
  input logic                 en
);
  logic [MAX_GRIDS-1:0] grids_low;
  assign grids_low = {mode7 && !shared_o, ~grid_o};

  assert_one_grid_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grids_low));

  assert_off_dark_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |-> (grids_low == '0) && (seg_o == '0));

  assert_key_dark_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_win_o |-> (grids_low == '0) && (seg_o == '0));

  assert_latch_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_latch_o |=> !key_latch_o);

  assert_latch_in_win_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    key_latch_o |-> key_win_o);

  assert_mode_blank_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode7 != $past(mode7)) && !$past(ctrl_wr_i) |-> !en);

  assert_seg_needs_grid_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seg_o != '0) |-> (grids_low != '0));
endmodule

bind led_scan_top led_scan_chk #(.MAX_GRIDS(MAX_GRIDS)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .ctrl_wr_i(ctrl_wr_i), .seg_o(seg_o),
  .grid_o(grid_o), .shared_o(shared_o), .key_win_o(key_win_o),
  .key_latch_o(key_latch_o), .mode7(mode7), .en(en)
);

// File: tb/sim_led_scan_top.sv
`timescale 1ns/1ps
module sim_led_scan_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         tick = 1'b0;
  logic [111:0] ram;
  logic         mode_wr = 1'b0;
  logic [1:0]   mode = 2'b00;
  logic         ctrl_wr = 1'b0;
  logic [2:0]   dim = 3'd0;
  logic         den = 1'b0;
  logic [10:0]  seg;
  logic [5:0]   grid;
  logic         shared, kwin, klatch;

  logic [7:0] ram_b [14];
  always_comb for (int k = 0; k < 14; k++) ram[8*k +: 8] = ram_b[k];

  always #5 clk = ~clk;

  led_scan_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .ram_i(ram),
    .mode_wr_i(mode_wr), .mode_i(mode), .ctrl_wr_i(ctrl_wr), .dim_i(dim),
    .disp_en_i(den), .seg_o(seg), .grid_o(grid), .shared_o(shared),
    .key_win_o(kwin), .key_latch_o(klatch)
  );

  int checks = 0, bad = 0, tick_div = 1, cyc = 0;
  string phase = "R1 reset";

  // reference model state
  int m_slot = 0, m_tick = 0, m_mode7 = 1, m_dim = 0, m_en = 0, m_latch = 0;

  function automatic int on_time(int c);
    int t [8] = '{1, 2, 4, 10, 11, 12, 13, 14};
    return t[c];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_slot = 0; m_tick = 0; m_mode7 = 1; m_dim = 0; m_en = 0; m_latch = 0;
    end else begin
      int ng, os, ot;
      bit rs;
      ng = m_mode7 ? 7 : 6;
      os = m_slot; ot = m_tick;
      rs = mode_wr && mode[1] && (int'(mode[0]) != m_mode7);
      m_latch = (tick && ot == 15 && os == ng - 1 && !rs) ? 1 : 0;
      if (rs) begin m_slot = 0; m_tick = 0; end
      else if (tick) begin
        if (ot == 15) begin m_tick = 0; m_slot = (os == ng) ? 0 : os + 1; end
        else m_tick = ot + 1;
      end
      if (rs) begin m_mode7 = mode[0]; m_en = 0; end
      if (ctrl_wr) begin m_dim = dim; m_en = den; end
    end
  end

  task automatic chk(string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual %h expected %h", phase, what, act, exp);
    end
  endtask

  task automatic compare();
    int ng;
    bit lit;
    logic [11:0] word;
    logic [5:0]  eg;
    logic        esh;
    ng  = m_mode7 ? 7 : 6;
    lit = m_en != 0 && m_slot < ng && m_tick < on_time(m_dim);
    word = (m_slot < 7) ? {ram_b[2*m_slot+1][3:0], ram_b[2*m_slot]} : 12'h0;
    eg = 6'h3f;
    if (m_en != 0 && m_slot < 6) eg[m_slot] = 1'b0;
    if (m_mode7 != 0) esh = !(m_en != 0 && m_slot == 6);
    else esh = lit && word[11];
    chk("R4 R6 seg", 16'(seg), lit ? 16'(word[10:0]) : 16'h0);
    chk("R5 grid", 16'(grid), 16'(eg));
    chk("R3 shared", 16'(shared), 16'(esh));
    chk("R9 key_win", 16'(kwin), 16'(m_slot == ng));
    chk("R9 key_latch", 16'(klatch), 16'(m_latch));
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      cyc++;
      compare();
      tick = (cyc % tick_div) == 0;
    end
  endtask

  task automatic wr_mode(logic [1:0] c);
    mode = c; mode_wr = 1'b1;
    step(1);
    mode_wr = 1'b0;
  endtask

  task automatic wr_ctrl(logic [2:0] d, logic e);
    dim = d; den = e; ctrl_wr = 1'b1;
    step(1);
    ctrl_wr = 1'b0;
  endtask

  task automatic fill(int seed);
    for (int k = 0; k < 14; k++) ram_b[k] = 8'((k * 37 + seed * 11) ^ 8'hA5);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  endtask

  initial begin
    #1_900_000;
    bad++;
    $display("FAIL watchdog R1: actual hung expected finished");
    finish_run();
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: explicit reset-state check
    @(negedge clk);
    chk("R1 grid", 16'(grid), 16'h3f);
    chk("R1 shared", 16'(shared), 16'h1);
    chk("R1 seg", 16'(seg), 16'h0);
    tick = 1'b1;
    step(5);

    phase = "R10 enable 7-grid"; wr_ctrl(3'd7, 1'b1); step(140);
    phase = "R5 scan 7-grid"; fill(1); step(140);
    for (int d = 0; d < 8; d++) begin
      phase = "R6 dim sweep"; wr_ctrl(3'(d), 1'b1); step(130);
    end
    phase = "R2 ignored codes"; wr_mode(2'b00); step(20); wr_mode(2'b01); step(20);
    phase = "R8 same mode"; wr_mode(2'b11); step(40);
    phase = "R8 mode change blanks"; wr_mode(2'b10); step(40);
    phase = "R3 6-grid shared seg"; wr_ctrl(3'd5, 1'b1); step(200);
    phase = "R4 unused nibble"; for (int k = 1; k < 14; k += 2) ram_b[k] = 8'hF8 | ram_b[k]; step(140);
    phase = "R7 display off"; wr_ctrl(3'd7, 1'b0); step(200);
    phase = "R10 simultaneous"; mode = 2'b11; mode_wr = 1'b1; dim = 3'd3; den = 1'b1; ctrl_wr = 1'b1;
    step(1); mode_wr = 1'b0; ctrl_wr = 1'b0; step(150);
    phase = "R4 unused nibble 7-grid"; fill(2); step(140);
    phase = "R9 sparse ticks"; tick_div = 3; step(450);
    phase = "R8 change in key slot";
    while (!kwin) step(1);
    step(3); wr_mode(2'b10); step(30); wr_ctrl(3'd1, 1'b1); step(400);
    tick_div = 1;
    phase = "R2 back to 7-grid"; wr_mode(2'b11); wr_ctrl(3'd6, 1'b1); step(300);
    finish_run();
  end
endmodule